// File: doc/BRIEF.md
# Timed Event Record Serializer

The serializer turns one timed output event into a variable-length byte record for a playback buffer. An event has a 64-bit timestamp, a 32-bit target word and between one and sixteen 32-bit data words. Bits [7:0] of the target word are a register address. Bits [31:8] are a 24-bit channel number. Once a request is accepted, the block sends the record one byte per handshake on a valid/ready output stream. The first byte of every record is that record's length.

The block keeps its own count of free bytes in the buffer. The `clr_i` strobe loads this count from `space_i`. The count drops by the record length when the last byte of a record is transferred. A request can be rejected in two ways. If it holds no data words or more than sixteen, the block pulses a length error. If the record would not fit in the remaining space, the block pulses an overflow error. In both cases nothing is sent, and the count is left unchanged.

Top module: `evt_rec_pack`

## Requirements
- R1: After reset, `out_valid_o` is 0, `req_ready_o` is 1, both error outputs are 0 and the free-space count is 0, so a legal request made before any `clr_i` is rejected as an overflow.
- R2: Byte 0 of every record is the record length, 13 + 4·N, where N is `req_nwords_i`.
- R3: Bytes 1, 2 and 3 are target bits [15:8], [23:16] and [31:24], in that order.
- R4: Bytes 4 through 11 are the timestamp, least significant byte first: byte 4+k is bits [8k+7:8k].
- R5: Byte 12 is target bits [7:0].
- R6: Each data word takes 4 bytes after the header, least significant byte first. Words go out in index order: word j is `req_data_i[32j+31:32j]`. `out_last_o` is 1 only on the final byte of the record.
- R7: A request with N = 0 or N > 16 sends nothing. `err_len_o` is 1 for exactly the cycle after the accepting edge.
- R8: A legal request whose length exceeds the free-space count sends nothing. `err_ovf_o` is 1 for exactly the cycle after the accepting edge.
- R9: A record that fits, including one that fills the count exactly, is sent. The count is then reduced by the record length at the transfer of its last byte.
- R10: `clr_i` loads the count from `space_i`. If it coincides with the last byte of a record, the load wins over the decrement.
- R11: `req_ready_o` is 0 from the accepting edge until the last byte has been transferred. While `out_ready_i` is 0, the output byte and last flag hold their values.
- R12: An accepted legal request shows its first byte with `out_valid_o` = 1 in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Load free-space count from `space_i` |
| space_i | input | SPACE_W | Free-space value to load |
| req_valid_i | input | 1 | Event request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_time_i | input | 64 | Event timestamp |
| req_target_i | input | 32 | Channel (bits 31:8) and address (bits 7:0) |
| req_nwords_i | input | 5 | Number of data words, legal 1..16 |
| req_data_i | input | 512 | Data words, word j at bits 32j+31:32j |
| out_valid_o | output | 1 | Record byte valid |
| out_ready_i | input | 1 | Sink takes the byte |
| out_data_o | output | 8 | Record byte |
| out_last_o | output | 1 | Final byte of the record |
| err_len_o | output | 1 | One-cycle pulse: illegal word count |
| err_ovf_o | output | 1 | One-cycle pulse: record does not fit |

## Verification
The free-space count never appears at a port. A wrong count only shows up later, as an overflow pulse on a request that should have been taken, or as a record sent when it should have been refused. For that reason the bench fills the count exactly and then probes it one request later. A corrupted byte index or latched field shows up at the very next handshake as a wrong byte or a misplaced last flag. A stuck state shows up within one cycle as a wrong `req_ready_o` or `out_valid_o`, because both are compared against the reference queue on every clock.

// File: rtl/evt_rec_pkg.sv
package evt_rec_pkg;
  localparam int unsigned MAX_WORDS = 16;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TS_W      = 64;
  localparam int unsigned TGT_W     = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned HDR_BYTES = 13;
  localparam int unsigned LEN_W     = 8;
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned WB        = WORD_W / 8;
  localparam int unsigned DAT_BYTES = MAX_WORDS * WB;
  localparam int unsigned DAT_W     = MAX_WORDS * WORD_W;
  localparam int unsigned MAX_LEN   = HDR_BYTES + DAT_BYTES;
  localparam int unsigned IDX_W     = $clog2(MAX_LEN);
  localparam int unsigned DB_W      = $clog2(DAT_BYTES);
  localparam int unsigned HB_W      = $clog2(HDR_BYTES);
  localparam int unsigned CH_BYTES  = (TGT_W - ADDR_W) / 8;
  localparam int unsigned TS_BYTES  = TS_W / 8;

  typedef enum logic {ST_IDLE, ST_SEND} st_e;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [TGT_W-1:0] tgt;
    logic [LEN_W-1:0] len;
  } hdr_t;
endpackage

// File: rtl/evt_req_check.sv
module evt_req_check
  import evt_rec_pkg::*;
#(
  parameter int unsigned SPACE_W = 16
) (
  input  logic [CNT_W-1:0]   nwords_i,
  input  logic [SPACE_W-1:0] free_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               bad_cnt_o,
  output logic               no_room_o
);
  assign len_o     = LEN_W'(HDR_BYTES) + LEN_W'({nwords_i, 2'b00});
  assign bad_cnt_o = (nwords_i == '0) || (nwords_i > CNT_W'(MAX_WORDS));
  assign no_room_o = free_i < SPACE_W'(len_o);
endmodule

// File: rtl/evt_space_track.sv
module evt_space_track
  import evt_rec_pkg::*;
#(
  parameter int unsigned SPACE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic               dec_i,
  input  logic [LEN_W-1:0]   amt_i,
  output logic [SPACE_W-1:0] free_o
);
  logic [SPACE_W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     free_q <= '0;
    else if (clr_i)  free_q <= space_i;  // load beats decrement
    else if (dec_i)  free_q <= free_q - SPACE_W'(amt_i);
  end

  assign free_o = free_q;
endmodule

// File: rtl/evt_byte_sel.sv
module evt_byte_sel
  import evt_rec_pkg::*;
(
  input  hdr_t             hdr_i,
  input  logic [DAT_W-1:0] data_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  logic [7:0] hb [2**HB_W];
  logic [7:0] db [DAT_BYTES];
  logic [DB_W-1:0] off;

  assign hb[0] = hdr_i.len;
  for (genvar g = 0; g < CH_BYTES; g++) begin : g_ch
    assign hb[1+g] = hdr_i.tgt[ADDR_W+8*g +: 8];
  end
  for (genvar g = 0; g < TS_BYTES; g++) begin : g_ts
    assign hb[1+CH_BYTES+g] = hdr_i.ts[8*g +: 8];
  end
  assign hb[HDR_BYTES-1] = hdr_i.tgt[ADDR_W-1:0];
  for (genvar g = HDR_BYTES; g < 2**HB_W; g++) begin : g_pad
    assign hb[g] = '0;
  end

  for (genvar g = 0; g < DAT_BYTES; g++) begin : g_db
    assign db[g] = data_i[8*g +: 8];
  end

  assign off    = DB_W'(idx_i - IDX_W'(HDR_BYTES));
  assign byte_o = (idx_i < IDX_W'(HDR_BYTES)) ? hb[idx_i[HB_W-1:0]] : db[off];
endmodule

// File: rtl/evt_rec_pack.sv
module evt_rec_pack
  import evt_rec_pkg::*;
#(
  parameter int unsigned SPACE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [TS_W-1:0]    req_time_i,
  input  logic [TGT_W-1:0]   req_target_i,
  input  logic [CNT_W-1:0]   req_nwords_i,
  input  logic [DAT_W-1:0]   req_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [7:0]         out_data_o,
  output logic               out_last_o,
  output logic               err_len_o,
  output logic               err_ovf_o
);
  st_e                st_q;
  logic [IDX_W-1:0]   idx_q;
  hdr_t               hdr_q;
  logic [DAT_W-1:0]   data_q;
  logic               err_len_q, err_ovf_q;
  logic [SPACE_W-1:0] free;
  logic [LEN_W-1:0]   len_c;
  logic               bad_c, noroom_c, accept, last, dec;

  evt_req_check #(.SPACE_W(SPACE_W)) u_chk_req (
    .nwords_i (req_nwords_i),
    .free_i   (free),
    .len_o    (len_c),
    .bad_cnt_o(bad_c),
    .no_room_o(noroom_c)
  );

  evt_space_track #(.SPACE_W(SPACE_W)) u_space (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .space_i(space_i),
    .dec_i  (dec),
    .amt_i  (hdr_q.len),
    .free_o (free)
  );

  evt_byte_sel u_sel (
    .hdr_i (hdr_q),
    .data_i(data_q),
    .idx_i (idx_q),
    .byte_o(out_data_o)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign last        = (idx_q == IDX_W'(hdr_q.len - LEN_W'(1)));
  assign dec         = (st_q == ST_SEND) && out_ready_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      hdr_q     <= '0;
      data_q    <= '0;
      err_len_q <= 1'b0;
      err_ovf_q <= 1'b0;
    end else begin
      err_len_q <= accept && bad_c;
      err_ovf_q <= accept && !bad_c && noroom_c;
      case (st_q)
        ST_IDLE: if (accept && !bad_c && !noroom_c) begin
          hdr_q  <= '{ts: req_time_i, tgt: req_target_i, len: len_c};
          data_q <= req_data_i;
          idx_q  <= '0;
          st_q   <= ST_SEND;
        end
        ST_SEND: if (out_ready_i) begin
          if (last) st_q  <= ST_IDLE;
          else      idx_q <= idx_q + IDX_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = (st_q == ST_SEND);
  assign out_last_o  = out_valid_o && last;
  assign err_len_o   = err_len_q;
  assign err_ovf_o   = err_ovf_q;
endmodule

// File: rtl/evt_rec_pack_chk.sv
module evt_rec_pack_chk
  import evt_rec_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [CNT_W-1:0] req_nwords_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic             out_last_o,
  input logic             err_len_o,
  input logic             err_ovf_o
);
  logic legal;
  assign legal = (req_nwords_i != '0) && (req_nwords_i <= CNT_W'(MAX_WORDS));

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !req_ready_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  // record starts with a length of form 13 + 4n, n in 1..16
  assert_len_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_data_o >= 8'd17 && out_data_o <= 8'd77 && out_data_o[1:0] == 2'b01);

  assert_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_len_rej_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !legal |=> err_len_o && !out_valid_o && !err_ovf_o);

  assert_no_emit_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovf_o |-> !out_valid_o && !err_len_o);

  assert_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && legal |=> out_valid_o != err_ovf_o);
endmodule

bind evt_rec_pack evt_rec_pack_chk u_chk (.*);

// File: tb/sim_evt_rec_pack.sv
`timescale 1ns/1ps
module sim_evt_rec_pack;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0;
  logic [15:0]  space_i = '0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [63:0]  req_time_i = '0;
  logic [31:0]  req_target_i = '0;
  logic [4:0]   req_nwords_i = '0;
  logic [511:0] req_data_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [7:0]   out_data_o;
  logic         out_last_o;
  logic         err_len_o, err_ovf_o;

  always #4 clk = ~clk;

  evt_rec_pack u0 (.clk_i(clk), .*);

  int    n_chk = 0, n_fail = 0;
  bit    run = 0, bp_mode = 0, done = 0;
  int    ncyc = 0;
  int    model_free = 0, pend_len = 0;
  bit    exp_len_err = 0, exp_ovf = 0;
  logic [7:0] exp_b[$];
  string      exp_t[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference comparison every cycle
  always @(negedge clk) if (run) begin
    out_ready_i = bp_mode ? (ncyc % 3 != 0) : 1'b1;
    ncyc++;
    chk(out_valid_o == (exp_b.size() != 0), "R12 valid", 64'(out_valid_o), 64'(exp_b.size() != 0));
    chk(req_ready_o == (exp_b.size() == 0), "R11 ready", 64'(req_ready_o), 64'(exp_b.size() == 0));
    chk(err_len_o == exp_len_err, "R7 err_len", 64'(err_len_o), 64'(exp_len_err));
    chk(err_ovf_o == exp_ovf, "R8 err_ovf", 64'(err_ovf_o), 64'(exp_ovf));
    if (out_valid_o && out_ready_i && exp_b.size() > 0) begin
      chk(out_data_o == exp_b[0], exp_t[0], 64'(out_data_o), 64'(exp_b[0]));
      chk(out_last_o == (exp_b.size() == 1), "R6 last", 64'(out_last_o), 64'(exp_b.size() == 1));
      if (exp_b.size() == 1) model_free -= pend_len;
      void'(exp_b.pop_front());
      void'(exp_t.pop_front());
    end
  end

  task automatic send(input logic [63:0] ts, input logic [31:0] tg, input int n,
                      input logic [31:0] seed, output bit ovf_seen);
    int len;
    logic [31:0] w;
    do @(negedge clk); while (!req_ready_o);
    req_time_i = ts; req_target_i = tg; req_nwords_i = 5'(n);
    req_data_i = '0;
    for (int j = 0; j < 16; j++) req_data_i[32*j +: 32] = seed * 32'h9E3779B1 + 32'(j) * 32'h01030507;
    req_valid_i = 1'b1;
    @(posedge clk); #1;
    len = 13 + 4 * n;
    if (n == 0 || n > 16) exp_len_err = 1;
    else if (model_free < len) exp_ovf = 1;
    else begin
      exp_b.push_back(8'(len)); exp_t.push_back("R2 length");
      for (int k = 1; k < 4; k++) begin exp_b.push_back(tg[8*k +: 8]); exp_t.push_back("R3 channel"); end
      for (int k = 0; k < 8; k++) begin exp_b.push_back(ts[8*k +: 8]); exp_t.push_back("R4 time"); end
      exp_b.push_back(tg[7:0]); exp_t.push_back("R5 addr");
      for (int j = 0; j < n; j++) begin
        w = req_data_i[32*j +: 32];
        for (int k = 0; k < 4; k++) begin exp_b.push_back(w[8*k +: 8]); exp_t.push_back("R6 data"); end
      end
      pend_len = len;
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    ovf_seen = err_ovf_o;
    @(posedge clk); #1;
    exp_len_err = 0; exp_ovf = 0;
  endtask

  task automatic load_space(input int v);
    @(negedge clk);
    clr_i = 1'b1; space_i = 16'(v);
    @(posedge clk); #1;
    model_free = v;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_b.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    bit o;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid_o == 0, "R1 valid", 64'(out_valid_o), 0);
    chk(req_ready_o == 1, "R1 ready", 64'(req_ready_o), 1);
    chk(err_len_o == 0 && err_ovf_o == 0, "R1 errs", 64'({err_len_o, err_ovf_o}), 0);
    rst_ni = 1'b1;
    run = 1;
    send(64'h1122334455667788, 32'hA1B2C3D4, 1, 1, o);
    chk(o == 1, "R1 zero space", 64'(o), 1);

    load_space(200);                                            // R10 idle load
    send(64'h0123456789ABCDEF, 32'h00ABCD5A, 1, 7, o); drain();
    bp_mode = 1;
    send(64'hFEDCBA9876543210, 32'hFFEE0102, 16, 3, o); drain(); // R11 backpressure
    bp_mode = 0;
    send(64'h5, 32'h00000100, 0, 2, o);                          // R7 zero words
    send(64'h6, 32'h00000200, 17, 2, o);                         // R7 too many
    send(64'hDEAD_BEEF_0000_0001, 32'h12345678, 3, 9, o); drain();
    send(64'h77, 32'h00000301, 16, 11, o); drain();              // free now 4
    send(64'h78, 32'h00000302, 1, 12, o);
    chk(o == 1, "R8 too little room", 64'(o), 1);

    load_space(29);
    send(64'hAA, 32'h00CAFE01, 4, 13, o); drain();               // exact fit
    chk(o == 0, "R9 exact fit", 64'(o), 0);
    send(64'hAB, 32'h00CAFE02, 1, 14, o);
    chk(o == 1, "R9 count reduced to zero", 64'(o), 1);

    // R10: load coinciding with last byte wins
    load_space(100);
    send(64'hBEEF, 32'h00F00D03, 1, 15, o);
    while (exp_b.size() != 1) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    clr_i = 1'b1; space_i = 16'd50;
    @(posedge clk); #1;
    model_free = 50;
    @(negedge clk); clr_i = 1'b0;
    send(64'hC0, 32'h00000404, 12, 16, o);
    chk(o == 1, "R10 load won over decrement", 64'(o), 1);
    send(64'hC1, 32'h00000405, 8, 17, o); drain();
    chk(o == 0, "R10 fits after load", 64'(o), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule